// File: doc/BRIEF.md
# Memory polynomial predistorter

This block sits in a transmit datapath just ahead of the power amplifier and bends each complex baseband sample so that the amplifier's own compression and memory effects are cancelled. Each output is a weighted sum over the current sample and the previous Q samples. Every one of those delayed samples is scaled by powers of its own envelope magnitude, and each (power, delay) pair has its own complex weight. A plain FIR filter has one weight per delay. This block has a bank of K envelope-power terms at every delay.

The magnitude of each accepted sample is computed once, as the floor of the exact square root, and is read as an unsigned value with 15 fractional bits. It then travels down a delay line next to its sample, so every tap reuses it. The weights are written one real or imaginary half at a time into a shadow table. A commit strobe copies the whole table into the working bank in a single edge, so no output ever mixes two weight sets. The block accepts one sample per clock, drops nothing and has a fixed latency of two clocks. With K = 1 and Q = 0 it collapses to a single complex gain.

Top module: `mpd_predistorter`

## Requirements
- R1: For each accepted sample the output is z = sum over k = 1..K and q = 0..Q of a(k,q) · y(n−q) · P(k,q). Here m = floor(sqrt(I² + Q²)) of y(n−q), taken as a value with 15 fractional bits. The power P starts at exactly 32768 (1.0) for k = 1, and each later power is (previous · m) >> 15. Each component of y·P is (component · P) shifted right by 15 with sign. Coefficients are signed 18-bit values with 14 fractional bits, and all products are accumulated at full precision.
- R2: out_valid is in_valid delayed by exactly two clock edges (LATENCY = 2). Every accepted sample yields exactly one output, in order, including under back-to-back input.
- R3: The delay history advances only on cycles with in_valid high, so idle cycles between samples do not change any later result. While out_valid is low, out_i and out_q hold their previous values.
- R4: Reset clears the delay line, out_valid, out_i and out_q to zero. The first Q outputs after reset use zero for the taps that have no sample yet.
- R5: After reset both the shadow and working banks hold 16384 (1.0) in the real part of a(1,0) and zero everywhere else, so the output equals the input.
- R6: A write with cw_en high stores cw_data in the shadow entry at address (k−1)·(Q+1)+q. cw_imag = 1 selects the imaginary half and 0 the real half. A write to an address of K·(Q+1) or more changes nothing.
- R7: Shadow writes have no effect on the output until cw_commit. A commit replaces the whole working bank in one edge: samples accepted on or after the commit edge use the new bank, and earlier samples use the old one.
- R8: Each output component is the accumulator plus 8192, shifted right by 14 with sign, so halves round toward +∞. The result then saturates to the range −32768..32767.
- R9: Built with K = 1 and Q = 0, the block outputs round(a·y), where a is the single committed complex coefficient, with the rounding and saturation of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 16 | Input in-phase component, signed |
| in_q | input | 16 | Input quadrature component, signed |
| cw_en | input | 1 | Shadow coefficient write strobe |
| cw_imag | input | 1 | 1 writes the imaginary half, 0 the real half |
| cw_addr | input | max(1, clog2(K·(Q+1))) | Coefficient index (k−1)·(Q+1)+q |
| cw_data | input | 18 | Coefficient half, signed, 14 fractional bits |
| cw_commit | input | 1 | Copies the shadow table into the working bank |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Predistorted in-phase component, signed |
| out_q | output | 16 | Predistorted quadrature component, signed |

## Verification
The bench drives the first samples after a fresh reset with weight only on the oldest tap, so that zero history is checked. A design that shifted in stale or undefined history would show extra energy there. Idle gaps are mixed into the random traffic, and shadow writes are placed in front of the commit strobe. A delay line that shifted every clock, or a bank that updated on the write itself, would produce outputs that the reference model does not predict. Writes to out-of-range addresses, full-scale inputs at the highest envelope powers, and values of exactly ±0.5 and ±1.5 probe the address guard, the accumulator width and the round-half-up with saturation. A second instance built as a single complex gain confirms that the general structure reduces correctly to the linear case.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
    localparam int SAMP_W    = 16;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 14;
    localparam int MAG_W     = 16;
    localparam int MAG_FRAC  = 15;
    localparam int POW_W     = 24;
    localparam int TERM_W    = 24;
    localparam int ACC_W     = 48;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic        [MAG_W-1:0]  mag_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    localparam coef_t COEF_ONE = coef_t'(1 << COEF_FRAC);
    localparam acc_t  SAT_HI   = acc_t'((1 << (SAMP_W-1)) - 1);
    localparam acc_t  SAT_LO   = -acc_t'(1 << (SAMP_W-1));
    localparam acc_t  RND_HALF = acc_t'(1 << (COEF_FRAC-1));

    function automatic samp_t clamp_sample(input acc_t v);
        if (v > SAT_HI) return samp_t'(SAT_HI);
        if (v < SAT_LO) return samp_t'(SAT_LO);
        return samp_t'(v);
    endfunction
endpackage

// File: rtl/mpd_magnitude.sv
module mpd_magnitude
    import mpd_pkg::*;
(
    input  samp_t re,
    input  samp_t im,
    output mag_t  mag
);
    localparam int PW = 2*SAMP_W;

    logic signed [PW-1:0] sq_re;
    logic signed [PW-1:0] sq_im;
    logic        [PW-1:0] energy;
    mag_t                 root;
    mag_t                 cand;

    always_comb begin
        sq_re  = PW'(re) * PW'(re);
        sq_im  = PW'(im) * PW'(im);
        energy = $unsigned(sq_re) + $unsigned(sq_im);
        root   = '0;
        cand   = '0;
        for (int b = MAG_W-1; b >= 0; b--) begin
            cand = root | (mag_t'(1) << b);
            if (PW'(cand) * PW'(cand) <= energy)
                root = cand;
        end
        mag = root;
    end
endmodule

// File: rtl/mpd_coef_bank.sv
module mpd_coef_bank
    import mpd_pkg::*;
#(
    parameter int N  = 72,
    parameter int AW = 7
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_imag,
    input  logic [AW-1:0] wr_addr,
    input  coef_t         wr_data,
    input  logic          commit,
    output coef_t         act_re [N],
    output coef_t         act_im [N]
);
    coef_t sh_re [N];
    coef_t sh_im [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                sh_re[i] <= (i == 0) ? COEF_ONE : '0;
                sh_im[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (wr_addr == AW'(i)) begin
                    if (wr_imag) sh_im[i] <= wr_data;
                    else         sh_re[i] <= wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                act_re[i] <= (i == 0) ? COEF_ONE : '0;
                act_im[i] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < N; i++) begin
                act_re[i] <= sh_re[i];
                act_im[i] <= sh_im[i];
            end
        end
    end
endmodule

// File: rtl/mpd_tap.sv
module mpd_tap
    import mpd_pkg::*;
#(
    parameter  int K    = 9,
    parameter  int NTAP = 8,
    parameter  int TAP  = 0,
    localparam int N    = K*NTAP
)(
    input  samp_t smp_re,
    input  samp_t smp_im,
    input  mag_t  mag,
    input  coef_t c_re [N],
    input  coef_t c_im [N],
    output acc_t  sum_re,
    output acc_t  sum_im
);
    localparam int XW  = SAMP_W + POW_W + 1;
    localparam int PPW = POW_W + MAG_W;

    logic        [POW_W-1:0]  pw;
    logic        [PPW-1:0]    pprod;
    logic signed [XW-1:0]     xr;
    logic signed [XW-1:0]     xi;
    logic signed [TERM_W-1:0] tr;
    logic signed [TERM_W-1:0] ti;
    acc_t                     cr;
    acc_t                     ci;

    always_comb begin
        pw     = POW_W'(1) << MAG_FRAC;
        sum_re = '0;
        sum_im = '0;
        pprod  = '0;
        xr = '0; xi = '0; tr = '0; ti = '0; cr = '0; ci = '0;
        for (int k = 0; k < K; k++) begin
            xr = XW'(smp_re) * XW'($signed({1'b0, pw}));
            xi = XW'(smp_im) * XW'($signed({1'b0, pw}));
            tr = TERM_W'(xr >>> MAG_FRAC);
            ti = TERM_W'(xi >>> MAG_FRAC);
            cr = acc_t'(c_re[k*NTAP + TAP]);
            ci = acc_t'(c_im[k*NTAP + TAP]);
            sum_re = sum_re + cr * acc_t'(tr) - ci * acc_t'(ti);
            sum_im = sum_im + cr * acc_t'(ti) + ci * acc_t'(tr);
            pprod  = PPW'(pw) * PPW'(mag);
            pw     = POW_W'(pprod >> MAG_FRAC);
        end
    end
endmodule

// File: rtl/mpd_predistorter.sv
module mpd_predistorter
    import mpd_pkg::*;
#(
    parameter  int K       = 9,
    parameter  int Q       = 7,
    localparam int NTAP    = Q + 1,
    localparam int NCOEF   = K * NTAP,
    localparam int ADDR_W  = (NCOEF > 1) ? $clog2(NCOEF) : 1,
    localparam int LATENCY = 2
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [SAMP_W-1:0] in_i,
    input  logic signed [SAMP_W-1:0] in_q,
    input  logic                     cw_en,
    input  logic                     cw_imag,
    input  logic [ADDR_W-1:0]        cw_addr,
    input  logic signed [COEF_W-1:0] cw_data,
    input  logic                     cw_commit,
    output logic                     out_valid,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q
);
    coef_t act_re [NCOEF];
    coef_t act_im [NCOEF];
    samp_t dl_re  [NTAP];
    samp_t dl_im  [NTAP];
    mag_t  dl_mag [NTAP];
    acc_t  tap_re [NTAP];
    acc_t  tap_im [NTAP];
    mag_t  in_mag;
    acc_t  tot_re, tot_im;
    acc_t  rnd_re, rnd_im;
    logic [LATENCY-1:0] vsr;

    mpd_magnitude u_mag (.re(in_i), .im(in_q), .mag(in_mag));

    mpd_coef_bank #(.N(NCOEF), .AW(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(cw_en), .wr_imag(cw_imag),
        .wr_addr(cw_addr), .wr_data(cw_data), .commit(cw_commit),
        .act_re(act_re), .act_im(act_im)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTAP; t++) begin
                dl_re[t]  <= '0;
                dl_im[t]  <= '0;
                dl_mag[t] <= '0;
            end
        end else if (in_valid) begin
            dl_re[0]  <= in_i;
            dl_im[0]  <= in_q;
            dl_mag[0] <= in_mag;
            for (int t = 1; t < NTAP; t++) begin
                dl_re[t]  <= dl_re[t-1];
                dl_im[t]  <= dl_im[t-1];
                dl_mag[t] <= dl_mag[t-1];
            end
        end
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        mpd_tap #(.K(K), .NTAP(NTAP), .TAP(t)) u_tap (
            .smp_re(dl_re[t]), .smp_im(dl_im[t]), .mag(dl_mag[t]),
            .c_re(act_re), .c_im(act_im),
            .sum_re(tap_re[t]), .sum_im(tap_im[t])
        );
    end

    always_comb begin
        tot_re = '0;
        tot_im = '0;
        for (int t = 0; t < NTAP; t++) begin
            tot_re = tot_re + tap_re[t];
            tot_im = tot_im + tap_im[t];
        end
        rnd_re = (tot_re + RND_HALF) >>> COEF_FRAC;
        rnd_im = (tot_im + RND_HALF) >>> COEF_FRAC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vsr   <= '0;
            out_i <= '0;
            out_q <= '0;
        end else begin
            vsr <= {vsr[LATENCY-2:0], in_valid};
            if (vsr[0]) begin
                out_i <= clamp_sample(rnd_re);
                out_q <= clamp_sample(rnd_im);
            end
        end
    end

    assign out_valid = vsr[LATENCY-1];
endmodule

// File: rtl/mpd_checker.sv
module mpd_checker
    import mpd_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  in_valid,
    input logic  out_valid,
    input logic  cw_commit,
    input samp_t out_i,
    input samp_t out_q,
    input coef_t bank_re0,
    input coef_t bank_im0
);
    // R2: every accepted sample appears two edges later
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R2: no output without a matching input
    assert_no_phantom_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R3: outputs hold between valid results
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_i) && $stable(out_q)));

    // R7: the working bank changes only on a commit
    assert_bank_atomic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cw_commit |=> ($stable(bank_re0) && $stable(bank_im0)));
endmodule

bind mpd_predistorter mpd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .cw_commit(cw_commit), .out_i(out_i), .out_q(out_q),
    .bank_re0(u_bank.act_re[0]), .bank_im0(u_bank.act_im[0])
);

// File: tb/mpd_predistorter_bench.sv
module mpd_predistorter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int KO = 9;
    localparam int QO = 7;
    localparam int NT = QO + 1;
    localparam int NC = KO * NT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic cw_en = 1'b0, cw_imag = 1'b0, cw_commit = 1'b0;
    logic [6:0] cw_addr = '0;
    logic signed [17:0] cw_data = '0;
    logic lin_cw_en = 1'b0, lin_cw_commit = 1'b0;
    logic [0:0] lin_cw_addr = '0;
    logic out_valid, lin_out_valid;
    logic signed [15:0] out_i, out_q, lin_out_i, lin_out_q;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpd_predistorter #(.K(KO), .Q(QO)) u_mpd_predistorter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cw_en(cw_en), .cw_imag(cw_imag), .cw_addr(cw_addr), .cw_data(cw_data),
        .cw_commit(cw_commit), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    mpd_predistorter #(.K(1), .Q(0)) u_mpd_predistorter_lin (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .cw_en(lin_cw_en), .cw_imag(cw_imag), .cw_addr(lin_cw_addr), .cw_data(cw_data),
        .cw_commit(lin_cw_commit), .out_valid(lin_out_valid), .out_i(lin_out_i), .out_q(lin_out_q)
    );

    longint mc_re [NC], mc_im [NC], ms_re [NC], ms_im [NC];
    longint lin_re, lin_im, lin_sre, lin_sim;
    longint hist_i [NT], hist_q [NT];
    int     exp_i [$], exp_q [$], lexp_i [$], lexp_q [$];
    string  exp_tag [$];
    string  mon_tag;
    int     checks = 0, fails = 0;
    logic   mon_on = 1'b0, vprev = 1'b0;

    task automatic check(string tag, string what, longint got, longint expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, expv);
        end
    endtask

    function automatic int rnd(int lo, int hi);
        return lo + int'($urandom % 32'(hi - lo + 1));
    endfunction

    function automatic longint isqrt(longint v);
        longint r = 0, c;
        for (int b = 15; b >= 0; b--) begin
            c = r | (longint'(1) << b);
            if (c * c <= v) r = c;
        end
        return r;
    endfunction

    function automatic int round_sat(longint acc);
        longint r = (acc + 8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic calc(output int zr, output int zi);
        longint ar = 0, ai = 0, m, p, tr, ti;
        int idx;
        for (int q = 0; q < NT; q++) begin
            m = isqrt(hist_i[q]*hist_i[q] + hist_q[q]*hist_q[q]);
            p = 32768;
            for (int k = 0; k < KO; k++) begin
                tr  = (hist_i[q] * p) >>> 15;
                ti  = (hist_q[q] * p) >>> 15;
                idx = k*NT + q;
                ar += mc_re[idx]*tr - mc_im[idx]*ti;
                ai += mc_re[idx]*ti + mc_im[idx]*tr;
                p   = (p * m) >>> 15;
            end
        end
        zr = round_sat(ar);
        zi = round_sat(ai);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            mc_re[i] = (i == 0) ? 16384 : 0; mc_im[i] = 0;
            ms_re[i] = mc_re[i];             ms_im[i] = 0;
        end
        for (int t = 0; t < NT; t++) begin hist_i[t] = 0; hist_q[t] = 0; end
        lin_re = 16384; lin_im = 0; lin_sre = 16384; lin_sim = 0;
    endtask

    task automatic clear_ctl();
        in_valid = 1'b0; cw_en = 1'b0; cw_commit = 1'b0;
        lin_cw_en = 1'b0; lin_cw_commit = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); clear_ctl(); end
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        @(negedge clk); clear_ctl(); rst_n = 1'b0;
        idle(3);
        exp_i.delete(); exp_q.delete(); lexp_i.delete(); lexp_q.delete(); exp_tag.delete();
        model_reset();
        rst_n = 1'b1;
        mon_on = 1'b1;
    endtask

    task automatic send(int si, int sq, string tag);
        int zr, zi;
        @(negedge clk); clear_ctl();
        in_valid = 1'b1; in_i = 16'(si); in_q = 16'(sq);
        for (int t = NT-1; t > 0; t--) begin hist_i[t] = hist_i[t-1]; hist_q[t] = hist_q[t-1]; end
        hist_i[0] = si; hist_q[0] = sq;
        calc(zr, zi);
        exp_i.push_back(zr); exp_q.push_back(zi); exp_tag.push_back(tag);
        lexp_i.push_back(round_sat(lin_re*si - lin_im*sq));
        lexp_q.push_back(round_sat(lin_re*sq + lin_im*si));
    endtask

    task automatic wr(int addr, bit imag, int data);
        @(negedge clk); clear_ctl();
        cw_en = 1'b1; cw_addr = 7'(addr); cw_imag = imag; cw_data = 18'(data);
        if (addr < NC) begin
            if (imag) ms_im[addr] = data; else ms_re[addr] = data;
        end
    endtask

    task automatic commit();
        @(negedge clk); clear_ctl(); cw_commit = 1'b1;
        for (int i = 0; i < NC; i++) begin mc_re[i] = ms_re[i]; mc_im[i] = ms_im[i]; end
    endtask

    task automatic lin_wr(bit imag, int data);
        @(negedge clk); clear_ctl();
        lin_cw_en = 1'b1; lin_cw_addr = 1'b0; cw_imag = imag; cw_data = 18'(data);
        if (imag) lin_sim = data; else lin_sre = data;
    endtask

    task automatic lin_commit();
        @(negedge clk); clear_ctl(); lin_cw_commit = 1'b1;
        lin_re = lin_sre; lin_im = lin_sim;
    endtask

    task automatic random_bank();
        for (int idx = 0; idx < NC; idx++) begin
            int k = idx / NT;
            int lim = (k == 0) ? ((idx == 0) ? 16000 : 4000) : (1500 >> (k - 1));
            wr(idx, 1'b0, rnd(-lim, lim));
            wr(idx, 1'b1, rnd(-lim, lim));
        end
    endtask

    task automatic random_sample(string tag);
        int amp;
        case (rnd(0, 2))
            0:       amp = 4000;
            1:       amp = 16000;
            default: amp = 32767;
        endcase
        send(rnd(-amp, amp), rnd(-amp, amp), tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            check("R2", "out_valid", longint'(out_valid), longint'(vprev));
            check("R9", "lin out_valid", longint'(lin_out_valid), longint'(vprev));
            if (out_valid && exp_i.size() > 0) begin
                mon_tag = exp_tag.pop_front();
                check(mon_tag, "out_i", longint'(out_i), longint'(exp_i.pop_front()));
                check(mon_tag, "out_q", longint'(out_q), longint'(exp_q.pop_front()));
            end
            if (lin_out_valid && lexp_i.size() > 0) begin
                check("R9", "lin out_i", longint'(lin_out_i), longint'(lexp_i.pop_front()));
                check("R9", "lin out_q", longint'(lin_out_q), longint'(lexp_q.pop_front()));
            end
        end
        vprev = in_valid;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd424242));
        model_reset();
        do_reset();
        @(negedge clk);
        check("R4", "reset out_valid", longint'(out_valid), 0);
        check("R4", "reset out_i", longint'(out_i), 0);
        check("R4", "reset out_q", longint'(out_q), 0);

        // R5: identity bank after reset, including full-scale corners
        send(32767, -32768, "R5");
        send(-32768, 32767, "R5");
        send(1234, -567, "R5");
        idle(3);

        // R4: fresh reset, weight only on the oldest tap plus identity
        do_reset();
        wr(0*NT + 7, 1'b0, 16384);
        wr(0*NT + 7, 1'b1, 8192);
        commit();
        for (int s = 0; s < 10; s++) send(1000*(s+1), -500*(s+1), "R4");
        idle(3);

        // R7: shadow writes without commit leave the bank unchanged
        random_bank();
        for (int s = 0; s < 12; s++) random_sample("R7");
        commit();
        for (int s = 0; s < 12; s++) random_sample("R7");

        // R6: out-of-range addresses are ignored
        for (int a = NC; a < 128; a += 5) wr(a, a[0], 100000);
        commit();
        for (int s = 0; s < 8; s++) random_sample("R6");

        // R3: idle gaps between samples
        for (int s = 0; s < 40; s++) begin
            random_sample("R3");
            idle(rnd(0, 3));
        end

        // R1: several random banks with mixed traffic
        for (int b = 0; b < 3; b++) begin
            random_bank();
            commit();
            for (int s = 0; s < 120; s++) begin
                random_sample("R1");
                if (rnd(0, 4) == 0) idle(rnd(1, 2));
            end
        end

        // R8: rounding of halves and saturation
        for (int i = 0; i < NC; i++) begin
            if (ms_re[i] != 0) wr(i, 1'b0, 0);
            if (ms_im[i] != 0) wr(i, 1'b1, 0);
        end
        wr(0, 1'b0, 8192);
        commit();
        send(1, -1, "R8"); send(3, -3, "R8"); send(-3, 3, "R8");
        for (int s = 0; s < 8; s++) send(0, 0, "R8");
        wr(0, 1'b0, 32768);
        commit();
        send(20000, -20000, "R8");
        send(-30000, 30000, "R8");
        send(16383, -16384, "R8");

        // R9: single complex gain instance
        lin_wr(1'b0, 20000);
        lin_wr(1'b1, -7000);
        for (int s = 0; s < 4; s++) random_sample("R9");
        lin_commit();
        for (int s = 0; s < 30; s++) random_sample("R9");
        lin_wr(1'b0, -131072);
        lin_wr(1'b1, 131071);
        lin_commit();
        send(32767, 32767, "R9");
        send(-32768, 100, "R9");
        for (int s = 0; s < 10; s++) random_sample("R9");

        idle(4);
        check("R2", "pending outputs", longint'(exp_i.size()), 0);
        check("R9", "pending lin outputs", longint'(lexp_i.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule